// File: doc/BRIEF.md
# Charger Event Interrupt Generator with Sticky Fault Register

This block tells a host processor that something happened in a battery charger. It does this by pulling an active-low interrupt line low for a fixed time. Four event strobes can start a pulse: source identified, good input found, input removed and charge complete. A vector of live fault conditions can also start one, on the first fault seen while the fault register is empty.

Fault bits are sticky. Once set, a bit stays in the fault register until the host issues a read strobe, even if the live condition has gone away. While the register holds any bit, further faults do not raise an interrupt. The four events are never held back by the fault register.

A read returns the register contents as they stood before the read. The read also reloads the register from the live fault vector. A second read straight after the first therefore returns the current fault status. Fault interrupts are armed again only after a read leaves the register empty.

The pulse length is a parameter pair: clock rate in MHz and width in microseconds. The defaults give 256 us at 250 MHz.

Top module: `chg_irq_ctrl`

## Requirements
- R1: A qualifying trigger sampled at a clock edge drives `irq_n_o` low from that edge. The line stays low for exactly CLK_MHZ*PULSE_US cycles and then returns high.
- R2: A one-cycle high on any bit of `evt_i` starts a pulse. Bit 0 is source identified, bit 1 is good input, bit 2 is input removed and bit 3 is charge complete.
- R3: When the fault register is all zero and `fault_i` has any bit set, a pulse starts and those bits are captured. A captured bit stays set until a read, even after the live bit clears.
- R4: While the fault register is non-zero, new fault bits are added to it but start no pulse. Event strobes still start pulses.
- R5: A trigger that arrives while a pulse is active neither extends nor restarts it.
- R6: A one-cycle `rd_i` makes `rd_data_o` equal to the fault register value before the read. The new value appears from the next cycle and is held until the next read. The same edge loads the register with the live `fault_i`.
- R7: A second read right after a first returns the live fault vector as reloaded by the first read, plus any bits that rose since.
- R8: If a read reloads a non-zero value, faults stay masked. A later fault raises a pulse only after a read has left the register at zero.
- R9: After reset `irq_n_o` is high, `rd_data_o` is zero and the fault register is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N_EVT | One-cycle event strobes (bit order as in R2) |
| fault_i | input | N_FAULT | Live fault condition levels |
| rd_i | input | 1 | One-cycle host read strobe for the fault register |
| irq_n_o | output | 1 | Active-low interrupt pulse |
| rd_data_o | output | N_FAULT | Fault register value returned by the last read |

## Verification
All inputs change on the falling clock edge. A trigger is taken at the next rising edge. `irq_n_o` is low at the falling edge that follows, so the bench counts low falling-edge samples from there and expects exactly the configured pulse length. Read data is registered once, so the bench checks `rd_data_o` one falling edge after the strobe. The bench confirms that a trigger had no effect by watching `irq_n_o` over a window a few cycles longer than one pulse. Expected fault values are formed in the bench as ORs of the vectors it applied, swept over every non-zero 4-bit pattern.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;
   // Event strobe positions within evt_i
   localparam int EVT_SRC_ID   = 0;
   localparam int EVT_GOOD_IN  = 1;
   localparam int EVT_IN_GONE  = 2;
   localparam int EVT_CHG_DONE = 3;
   localparam int EVT_COUNT    = 4;

   function automatic int pulse_cycles(input int clk_mhz, input int width_us);
      return clk_mhz * width_us;
   endfunction

   function automatic int cnt_width(input int cycles);
      return (cycles < 2) ? 1 : $clog2(cycles);
   endfunction
endpackage

// File: rtl/chg_irq_fault_latch.sv
module chg_irq_fault_latch
   import chg_irq_pkg::*;
#(
   parameter int N_FAULT = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_FAULT-1:0] fault_i,
   input  logic               rd_i,
   output logic [N_FAULT-1:0] latch_o,
   output logic [N_FAULT-1:0] rd_data_o,
   output logic               fault_trig_o
);
   logic [N_FAULT-1:0] flt_q;
   logic [N_FAULT-1:0] rdd_q;
   logic               empty;

   generate
      if (N_FAULT < 1 || N_FAULT > 32) begin : g_bad_width
         $error("chg_irq_fault_latch: N_FAULT must lie in 1..32");
      end
      for (genvar b = 0; b < N_FAULT; b++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          flt_q[b] <= 1'b0;
            else if (rd_i)       flt_q[b] <= fault_i[b];
            else if (fault_i[b]) flt_q[b] <= 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdd_q <= '0;
      else if (rd_i) rdd_q <= flt_q;
   end

   assign empty        = (flt_q == '0);
   assign fault_trig_o = empty && (fault_i != '0);
   assign latch_o      = flt_q;
   assign rd_data_o    = rdd_q;

   // Captured bits never drop without a host read
   AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> ((flt_q & $past(flt_q)) == $past(flt_q))); // R3
endmodule

// File: rtl/chg_irq_pulse_timer.sv
module chg_irq_pulse_timer
   import chg_irq_pkg::*;
#(
   parameter int PULSE_CYC = 64000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   output logic irq_n_o
);
   localparam int CW = cnt_width(PULSE_CYC);
   localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC - 1);

   logic [CW-1:0] cnt_q;
   logic          irq_n_q;

   generate
      if (PULSE_CYC < 1) begin : g_bad_len
         $error("chg_irq_pulse_timer: PULSE_CYC must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_n_q <= 1'b1;
         cnt_q   <= '0;
      end else if (irq_n_q) begin
         if (trig_i) begin
            irq_n_q <= 1'b0;
            cnt_q   <= LOAD;
         end
      end else if (cnt_q == '0) begin
         irq_n_q <= 1'b1;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign irq_n_o = irq_n_q;

   // Checker: count low cycles independently of the down-counter
   int unsigned low_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       low_cnt <= 0;
      else if (irq_n_q) low_cnt <= 0;
      else              low_cnt <= low_cnt + 1;
   end

   AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_n_q) |-> (low_cnt == PULSE_CYC)); // R1
   AST_NO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n_q |-> (low_cnt < PULSE_CYC)); // R5
endmodule

// File: rtl/chg_irq_ctrl.sv
module chg_irq_ctrl
   import chg_irq_pkg::*;
#(
   parameter int N_FAULT  = 8,
   parameter int N_EVT    = EVT_COUNT,
   parameter int CLK_MHZ  = 250,
   parameter int PULSE_US = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_EVT-1:0]   evt_i,
   input  logic [N_FAULT-1:0] fault_i,
   input  logic               rd_i,
   output logic               irq_n_o,
   output logic [N_FAULT-1:0] rd_data_o
);
   localparam int PULSE_CYC = pulse_cycles(CLK_MHZ, PULSE_US);

   logic [N_FAULT-1:0] latch;
   logic               fault_trig;
   logic               evt_any;
   logic               trig;

   generate
      if (N_EVT != EVT_COUNT) begin : g_bad_evt
         $error("chg_irq_ctrl: N_EVT must match the four defined events");
      end
   endgenerate

   chg_irq_fault_latch #(.N_FAULT(N_FAULT)) u_latch (
      .clk          (clk),
      .rst_n        (rst_n),
      .fault_i      (fault_i),
      .rd_i         (rd_i),
      .latch_o      (latch),
      .rd_data_o    (rd_data_o),
      .fault_trig_o (fault_trig)
   );

   assign evt_any = |evt_i;
   assign trig    = evt_any | fault_trig;

   chg_irq_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig_i  (trig),
      .irq_n_o (irq_n_o)
   );

   AST_FAULT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (latch != '0) && !evt_any && irq_n_o |=> irq_n_o); // R4
   AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n_o) |-> $past(evt_any || fault_trig)); // R2
endmodule

// File: tb/tb_chg_irq_ctrl.sv
`timescale 1ns/1ps
module tb_chg_irq_ctrl;
   localparam int NF = 4;
   localparam int P  = 250;   // 250 MHz * 1 us

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    evt_i = '0;
   logic [NF-1:0] fault_i = '0;
   logic          rd_i = 1'b0;
   logic          irq_n_o;
   logic [NF-1:0] rd_data_o;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   chg_irq_ctrl #(.N_FAULT(NF), .CLK_MHZ(250), .PULSE_US(1)) dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .fault_i(fault_i),
      .rd_i(rd_i), .irq_n_o(irq_n_o), .rd_data_o(rd_data_o)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Count consecutive low samples starting at the current negedge
   task automatic measure(input string req, input int exp);
      int w = 0;
      while (irq_n_o == 1'b0 && w < P + 10) begin
         w++;
         tick();
      end
      check(req, w, exp);
   endtask

   // Count low samples over a window longer than a pulse
   task automatic quiet(input string req);
      int lows = 0;
      for (int k = 0; k < P + 5; k++) begin
         if (irq_n_o == 1'b0) lows++;
         tick();
      end
      check(req, lows, 0);
   endtask

   task automatic strobe_evt(input int i);
      evt_i[i] = 1'b1;
      tick();
      evt_i = '0;
   endtask

   task automatic host_read(output logic [NF-1:0] d);
      rd_i = 1'b1;
      tick();
      rd_i = 1'b0;
      d = rd_data_o;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      logic [NF-1:0] d;
      repeat (3) tick();
      // R9 reset state
      check("R9 irq_n", irq_n_o, 1);
      check("R9 rd_data", rd_data_o, 0);
      rst_n = 1'b1;
      tick();
      host_read(d);
      check("R9 latch empty", d, 0);
      quiet("R9 no pulse");

      // R2/R1 every event bit
      for (int i = 0; i < 4; i++) begin
         strobe_evt(i);
         measure("R2 R1 event pulse", P);
         tick();
      end

      // R5 retrigger mid-pulse does not extend
      begin
         int w = 0;
         strobe_evt(0);
         for (int k = 0; k < P / 2; k++) begin
            if (!irq_n_o) w++;
            tick();
         end
         evt_i[1] = 1'b1;
         fault_i = 4'h0;
         if (!irq_n_o) w++;
         tick();
         evt_i = '0;
         while (!irq_n_o && w < 2 * P) begin
            w++;
            tick();
         end
         check("R5 width unchanged", w, P);
         tick();
      end

      // Sweep all non-zero fault vectors
      for (int v = 1; v < 16; v++) begin
         logic [NF-1:0] w2;
         w2 = NF'((v * 5 + 3) & 15);
         fault_i = NF'(v);
         tick();
         fault_i = '0;
         measure("R3 R1 fault pulse", P);
         // masked additional fault
         fault_i = w2;
         tick();
         tick();
         fault_i = '0;
         quiet("R4 fault masked");
         // events still pass
         strobe_evt(3);
         measure("R4 event unmasked", P);
         host_read(d);
         check("R6 R3 sticky read", int'(d), int'(NF'(v) | w2));
         host_read(d);
         check("R7 second read live", int'(d), 0);
      end

      // R8 persistent fault keeps mask after read
      fault_i = 4'h1;
      tick();
      measure("R8 first pulse", P);
      host_read(d);
      check("R6 read latched", d, 1);
      quiet("R8 still masked");
      fault_i = 4'h0;
      tick();
      host_read(d);
      check("R7 pre-clear read", d, 1);
      host_read(d);
      check("R7 live read", d, 0);
      fault_i = 4'h2;
      tick();
      fault_i = 4'h0;
      measure("R8 rearmed pulse", P);
      // R6 read and fault in same cycle: reload takes live value
      fault_i = 4'h8;
      host_read(d);
      fault_i = 4'h0;
      check("R6 read data old", d, 2);
      tick();
      host_read(d);
      check("R6 reload live", d, 8);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule